// File: doc/BRIEF.md
# Programmable Countdown Timer with Zero Interrupt

This block is a 32-bit down-counter controlled through a small word-addressed register bank. Software programs a start value and a refill value, then sets the run flag. The counter starts from the start value, steps down once per clock, and refills from the refill value each time it reaches zero. There is no mode bit. A refill value of zero makes the counter stop at zero after a single run (one-shot). A start value of zero with a nonzero refill gives a repeating period (periodic).

The live count cannot be read directly. Software writes any value to a snapshot register, and the block copies the count into a readable capture register. A single event source reports whether the count is nonzero. When that level drops to zero, a sticky pending flag is set, and the flag is cleared by writing a one to it. The interrupt line is asserted when the pending flag is set and its enable bit is set.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, every register and the count are 0 and `irq` is 0.
- R2: Word index `bus_addr[4:2]` selects the register: 0 start value, 1 refill value, 2 run flag (bit 0), 3 snapshot trigger (reads 0), 4 captured count, 5 event level (bit 0), 6 pending (bit 0), 7 event enable (bit 0). Unused upper bits read 0. The start and refill values read back as written.
- R3: Writing index 2 with bit 0 = 1 while the run flag is 0 loads the count from the start value at that clock edge. Writing 1 while already running does not reload the count.
- R4: While running with a nonzero count, the count decreases by one on every clock.
- R5: While running with a count of 0, the next clock loads the refill value. With a refill value of 0 the count stays at 0 (one-shot).
- R6: With a start value of 0 and a refill value of P, the count is 0 during the first running cycle. After that it follows P, P-1, …, 0 and repeats, so zero is reached every P+1 cycles.
- R7: Writing 0 to the run flag stops the counter, and the count then holds its value.
- R8: A write of any data to index 3 copies the count present before that edge into the captured-count register. The captured count changes at no other time, and writes to index 4 are ignored.
- R9: The event level (index 5, bit 0) is 1 when the count is nonzero. Writes to index 5 have no effect.
- R10: Pending bit 0 is set one clock after the event level falls from 1 to 0. Writing 1 to index 6 bit 0 clears it. If the set and the clear fall on the same edge, the set wins.
- R11: `irq` is 1 exactly when pending bit 0 and event-enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte address, bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
Two pairs of functions can act on the same edge. In the first, a write that clears the pending flag meets the falling edge of the zero event. The bench provokes this by starting the counter from 2 with a refill value of 0 and timing the clear write to the exact edge where pending would be set; the pending flag must read 1 afterwards. In the second, a snapshot write meets a decrement or a refill. Here the captured value must be the count from before the edge. A cycle-level reference model in the bench checks this case throughout the random phase.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int REG_IDX_W = 3;
    localparam int REG_LSB   = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_START  = 3'd0,
        RG_REFILL = 3'd1,
        RG_RUN    = 3'd2,
        RG_SNAP   = 3'd3,
        RG_CAPT   = 3'd4,
        RG_LEVEL  = 3'd5,
        RG_PEND   = 3'd6,
        RG_EVENA  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic run;    // counter advances
        logic start;  // load from start value this edge
    } core_ctl_t;

    function automatic logic wr_hit(logic we, reg_sel_e sel, reg_sel_e target);
        return we && (sel == target);
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 5,
    parameter int N_EV = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   cnt,
    input  logic [N_EV-1:0] ev_lvl,
    input  logic [N_EV-1:0] ev_pend,
    output logic [DW-1:0]   start_q,
    output logic [DW-1:0]   refill_q,
    output core_ctl_t       ctl,
    output logic [N_EV-1:0] ev_ena,
    output logic [N_EV-1:0] ev_clr,
    output logic [DW-1:0]   capt_q
);

    reg_sel_e sel;
    logic     run_q;

    assign sel = reg_sel_e'(bus_addr[REG_LSB +: REG_IDX_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            refill_q <= '0;
            run_q    <= 1'b0;
            capt_q   <= '0;
            ev_ena   <= '0;
        end else if (bus_we) begin
            case (sel)
                RG_START:  start_q  <= bus_wdata;
                RG_REFILL: refill_q <= bus_wdata;
                RG_RUN:    run_q    <= bus_wdata[0];
                RG_SNAP:   capt_q   <= cnt;
                RG_EVENA:  ev_ena   <= bus_wdata[N_EV-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        ctl.run   = run_q;
        ctl.start = wr_hit(bus_we, sel, RG_RUN) && bus_wdata[0] && !run_q;
        ev_clr    = wr_hit(bus_we, sel, RG_PEND) ? bus_wdata[N_EV-1:0] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RG_START:  bus_rdata = start_q;
            RG_REFILL: bus_rdata = refill_q;
            RG_RUN:    bus_rdata[0] = run_q;
            RG_CAPT:   bus_rdata = capt_q;
            RG_LEVEL:  bus_rdata[N_EV-1:0] = ev_lvl;
            RG_PEND:   bus_rdata[N_EV-1:0] = ev_pend;
            RG_EVENA:  bus_rdata[N_EV-1:0] = ev_ena;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  core_ctl_t     ctl,
    input  logic [DW-1:0] start_val,
    input  logic [DW-1:0] refill_val,
    output logic [DW-1:0] cnt,
    output logic          nonzero
);

    logic at_zero;

    assign at_zero = (cnt == '0);
    assign nonzero = !at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ctl.start) begin
            cnt <= start_val;
        end else if (ctl.run) begin
            cnt <= at_zero ? refill_val : (cnt - DW'(1));
        end
    end

endmodule

// File: rtl/cdt_evmgr.sv
module cdt_evmgr #(
    parameter int N_EV = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EV-1:0] src_lvl,
    input  logic [N_EV-1:0] clr,
    input  logic [N_EV-1:0] ena,
    output logic [N_EV-1:0] pend,
    output logic            irq
);

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic prev_q;
        logic pend_q;
        logic fall;

        assign fall = prev_q && !src_lvl[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= src_lvl[g];
                if (fall)
                    pend_q <= 1'b1;
                else if (clr[g])
                    pend_q <= 1'b0;
            end
        end

        assign pend[g] = pend_q;
    end

    assign irq = |(pend & ena);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    localparam int N_EV = 1;

    core_ctl_t       ctl;
    logic [DW-1:0]   start_q;
    logic [DW-1:0]   refill_q;
    logic [DW-1:0]   cnt_w;
    logic [DW-1:0]   capt_w;
    logic            nz_w;
    logic [N_EV-1:0] ev_lvl;
    logic [N_EV-1:0] ev_pend;
    logic [N_EV-1:0] ev_ena;
    logic [N_EV-1:0] ev_clr;
    logic            run_w;
    logic            start_w;

    assign ev_lvl  = {N_EV{nz_w}};
    assign run_w   = ctl.run;
    assign start_w = ctl.start;

    cdt_regs #(.DW(DW), .AW(AW), .N_EV(N_EV)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt_w),
        .ev_lvl    (ev_lvl),
        .ev_pend   (ev_pend),
        .start_q   (start_q),
        .refill_q  (refill_q),
        .ctl       (ctl),
        .ev_ena    (ev_ena),
        .ev_clr    (ev_clr),
        .capt_q    (capt_w)
    );

    cdt_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .start_val  (start_q),
        .refill_val (refill_q),
        .cnt        (cnt_w),
        .nonzero    (nz_w)
    );

    cdt_evmgr #(.N_EV(N_EV)) u_ev (
        .clk     (clk),
        .rst     (rst),
        .src_lvl (ev_lvl),
        .clr     (ev_clr),
        .ena     (ev_ena),
        .pend    (ev_pend),
        .irq     (irq)
    );

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          run,
    input logic          start,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] start_val,
    input logic [DW-1:0] refill_val,
    input logic [DW-1:0] capt,
    input logic          lvl,
    input logic          pend,
    input logic          ena,
    input logic          irq
);

    logic snap_wr;
    assign snap_wr = bus_we && (bus_addr[4:2] == 3'd3);

    assert_load_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt == $past(start_val));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cnt != '0) |=> cnt == $past(cnt) - DW'(1));

    assert_refill_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !start && cnt == '0) |=> cnt == $past(refill_val));

    assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt));

    assert_capture_copy_R8: assert property (@(posedge clk) disable iff (rst)
        snap_wr |=> capt == $past(cnt));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !snap_wr |=> $stable(capt));

    assert_pend_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl) |=> pend);

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> ena);

    assert_irq_when_armed_R11: assert property (@(posedge clk) disable iff (rst)
        (pend && ena) |-> irq);

endmodule

bind cdt_timer cdt_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .run        (run_w),
    .start      (start_w),
    .cnt        (cnt_w),
    .start_val  (start_q),
    .refill_val (refill_q),
    .capt       (capt_w),
    .lvl        (nz_w),
    .pend       (ev_pend[0]),
    .ena        (ev_ena[0]),
    .irq        (irq)
);

// File: tb/sim_cdt_timer.sv
`timescale 1ns/1ps
module sim_cdt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cdt_timer u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model, built from the requirements
    logic [31:0] m_start, m_refill, m_cnt, m_capt;
    logic        m_run, m_pend, m_ena, m_prev;

    always @(posedge clk) begin
        logic [2:0]  idx;
        logic [31:0] n_cnt;
        logic        lvl, fall, strt;
        if (rst) begin
            m_start = 0; m_refill = 0; m_cnt = 0; m_capt = 0;
            m_run = 0; m_pend = 0; m_ena = 0; m_prev = 0;
        end else begin
            idx  = bus_addr[4:2];
            lvl  = (m_cnt != 0);
            fall = m_prev && !lvl;
            strt = bus_we && idx == 3'd2 && bus_wdata[0] && !m_run;
            if (strt)       n_cnt = m_start;
            else if (m_run) n_cnt = (m_cnt == 0) ? m_refill : m_cnt - 1;
            else            n_cnt = m_cnt;
            if (fall) m_pend = 1'b1;
            else if (bus_we && idx == 3'd6 && bus_wdata[0]) m_pend = 1'b0;
            if (bus_we) begin
                case (idx)
                    3'd0: m_start  = bus_wdata;
                    3'd1: m_refill = bus_wdata;
                    3'd2: m_run    = bus_wdata[0];
                    3'd3: m_capt   = m_cnt;
                    3'd7: m_ena    = bus_wdata[0];
                    default: ;
                endcase
            end
            m_prev = lvl;
            m_cnt  = n_cnt;
        end
    end

    function automatic logic [31:0] model_rd(int i);
        case (i)
            0: return m_start;
            1: return m_refill;
            2: return {31'd0, m_run};
            4: return m_capt;
            5: return {31'd0, m_cnt != 0};
            6: return {31'd0, m_pend};
            7: return {31'd0, m_ena};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(int idx, logic [31:0] d);
        bus_we = 1'b1; bus_addr = 5'(idx << 2); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] d);
        bus_addr = 5'(idx << 2);
        #0.01;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp_all(string req);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            chk(req, d, model_rd(i));
        end
        chk({req, " R11 irq"}, {31'd0, irq}, {31'd0, m_pend & m_ena});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d, d2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cmp_all("R1 reset");
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        // R2 readback, R3 start load, R5 one-shot
        wr(0, 32'd5); wr(1, 32'd0);
        rd(0, d); chk("R2 start readback", d, 32'd5);
        wr(2, 32'd1);
        wr(3, 32'hFFFF_FFFF);
        rd(4, d); chk("R3 load on start", d, 32'd5);
        wr(2, 32'd1);              // already running: no reload
        wr(3, 32'd0);
        rd(4, d); chk("R3 no reload while running", d, 32'd3);
        idle(6);
        wr(3, 32'd0);
        rd(4, d); chk("R5 one-shot stays zero", d, 32'd0);
        rd(6, d); chk("R10 pending after zero", d, 32'd1);
        cmp_all("R5 one-shot");

        // R7 stop holds count
        wr(2, 32'd0); wr(0, 32'd40); wr(2, 32'd1); idle(3);
        wr(2, 32'd0);
        wr(3, 32'd0); rd(4, d);
        idle(4);
        wr(3, 32'd0); rd(4, d2);
        chk("R7 hold when stopped", d2, d);
        cmp_all("R7 stopped");

        // R9 writes to level ignored, R8 writes to capture ignored
        wr(5, 32'd0); rd(5, d); chk("R9 level write ignored", d, 32'd1);
        wr(4, 32'hDEAD_BEEF); rd(4, d); chk("R8 capture write ignored", d, d2);

        // R6 periodic
        wr(6, 32'd1); wr(0, 32'd0); wr(1, 32'd3); wr(7, 32'd1);
        wr(2, 32'd1);
        rd(5, d); chk("R6 count zero first cycle", d, 32'd0);
        for (int k = 0; k < 14; k++) begin
            cmp_all("R6 periodic");
            if (k == 6) wr(6, 32'd1); else idle(1);
        end

        // R10 set wins over simultaneous clear
        wr(2, 32'd0); wr(6, 32'd1); wr(1, 32'd0); wr(0, 32'd2);
        wr(2, 32'd1);
        idle(2);
        wr(6, 32'd1);
        rd(6, d); chk("R10 set beats clear", d, 32'd1);
        chk("R11 irq with pend and enable", {31'd0, irq}, 32'd1);
        wr(7, 32'd0);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(6, 32'd1);
        rd(6, d); chk("R10 clear by write-one", d, 32'd0);

        // random phase, R2 R4 R5 R8 R9 R10 R11 via model
        for (int it = 0; it < 600; it++) begin
            int idx;
            logic [31:0] v;
            idx = int'($urandom_range(0, 7));
            v = ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 12));
            if (idx == 2 || idx == 7) v = 32'($urandom_range(0, 1));
            wr(idx, v);
            idle(int'($urandom_range(0, 4)));
            cmp_all("R4 random");
        end

        summary();
    end

endmodule